// File: doc/BRIEF.md
# Execution Mode and Banked Stack Pointer Unit

This unit keeps the execution state of a small microcontroller core. It knows whether the core runs ordinary code (thread mode) or services an exception (handler mode). It works out the privilege that is in force, and it holds the two banked stack pointers: a main one and a process one. The core reports exception entries and returns as single-cycle strobes and can write a two-bit control word. It also reads and writes "the" stack pointer without knowing which physical copy answers.

Nested exceptions are tracked by a saturating depth counter, so the unit leaves handler mode only when the outermost handler returns. Entry does not touch the stored control bits, so a return finds the thread's privilege and stack choice as they were, unless a privileged handler changed them. All inputs are sampled on the rising clock edge, and every output is a register that shows the state after that edge.

Top module: `mode_sp_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge show thread mode (`mode_handler`=0), `priv_eff`=1, `sp_is_process`=0, `priv_fault`=0 and `sp_rdata`=`MSP_RESET`. The stored control bits are cleared.
- R2: An `exc_enter` pulse makes `mode_handler` read 1 after the next edge.
- R3: While `mode_handler` is 1, `priv_eff` is 1 whatever the stored unprivileged bit holds.
- R4: In thread mode, `priv_eff` is the inverse of the stored unprivileged bit. That bit is written from `ctl_unpriv` (1 = unprivileged).
- R5: Handler mode always uses the main stack pointer. Thread mode uses the process stack pointer only when the stored stack-select bit (written from `ctl_psel`, 1 = process) is set. `sp_is_process` reports the copy in use, and `sp_rdata` shows that copy's value.
- R6: An `sp_we` write goes only to the copy that is active in that cycle. The other copy keeps its value.
- R7: A written stack-pointer value has its low `ALIGN_BITS` bits forced to zero.
- R8: A `ctl_we` write made in thread mode while unprivileged changes no control bit. It raises `priv_fault` for exactly the following cycle. No other write raises it.
- R9: Each exception entry raises the nesting depth and each return lowers it. The unit returns to thread mode only when the depth reaches zero. A return strobe in thread mode is ignored.
- R10: After the final return, thread mode resumes with the stored privilege and stack-select bits. A privileged control write made inside a handler takes effect at that point.
- R11: When `exc_enter` and `exc_return` arrive together, the depth is unchanged if it is non-zero and becomes 1 if it is zero. The depth saturates at 2^`DEPTH_W`-1, and further entries are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ctl_we | input | 1 | Control word write enable |
| ctl_unpriv | input | 1 | Written unprivileged bit (1 = unprivileged in thread mode) |
| ctl_psel | input | 1 | Written stack-select bit (1 = process stack in thread mode) |
| sp_we | input | 1 | Stack pointer write enable |
| sp_wdata | input | SP_W | Stack pointer write value |
| mode_handler | output | 1 | 1 = handler mode, 0 = thread mode |
| priv_eff | output | 1 | 1 = privileged in effect |
| sp_is_process | output | 1 | 1 = process stack pointer active |
| sp_rdata | output | SP_W | Value of the active stack pointer |
| priv_fault | output | 1 | One-cycle pulse after an illegal control write |

## Verification
The bench goes after the cases where mode and control bits interact. One is an unprivileged thread trying to change its own control word: a design that let the write through would hand out privilege and never flag it. Another is a handler running with the unprivileged bit stored: a design that read the bit directly would drop privilege inside the handler. Nested and saturated entries, and simultaneous entry and return, expose a depth counter that leaves handler mode too early or wraps to zero. Writes to the stack pointer in each mode show whether the wrong copy is updated or the low address bits escape the alignment mask.

// File: rtl/mode_sp_pkg.sv
package mode_sp_pkg;
  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } exec_mode_e;

  typedef enum logic {
    SP_MAIN = 1'b0,
    SP_PROC = 1'b1
  } sp_sel_e;

  function automatic sp_sel_e pick_sp(input logic in_handler, input logic psel);
    return (!in_handler && psel) ? SP_PROC : SP_MAIN;
  endfunction
endpackage

// File: rtl/exc_nest_track.sv
module exc_nest_track #(
  parameter int DEPTH_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic leave,
  output logic in_handler_q,
  output logic in_handler_nxt
);
  localparam logic [DEPTH_W-1:0] MAX_DEPTH = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] ONE       = {{(DEPTH_W-1){1'b0}}, 1'b1};

  logic [DEPTH_W-1:0] depth_q;
  logic [DEPTH_W-1:0] depth_nxt;
  logic               inc;
  logic               dec;

  always_comb begin
    inc = enter && (depth_q != MAX_DEPTH);
    dec = leave && (depth_q != '0);
    unique case ({inc, dec})
      2'b10:   depth_nxt = depth_q + ONE;
      2'b01:   depth_nxt = depth_q - ONE;
      default: depth_nxt = depth_q;
    endcase
    in_handler_nxt = (depth_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q      <= '0;
      in_handler_q <= 1'b0;
    end else begin
      depth_q      <= depth_nxt;
      in_handler_q <= in_handler_nxt;
    end
  end
endmodule

// File: rtl/priv_ctrl_reg.sv
module priv_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic handler_now,
  input  logic we,
  input  logic wd_unpriv,
  input  logic wd_psel,
  output logic unpriv_q,
  output logic psel_q,
  output logic unpriv_nxt,
  output logic psel_nxt,
  output logic fault_q
);
  logic illegal;
  logic accept;

  always_comb begin
    illegal    = we && !handler_now && unpriv_q;
    accept     = we && !illegal;
    unpriv_nxt = accept ? wd_unpriv : unpriv_q;
    psel_nxt   = accept ? wd_psel   : psel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unpriv_q <= 1'b0;
      psel_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      unpriv_q <= unpriv_nxt;
      psel_q   <= psel_nxt;
      fault_q  <= illegal;
    end
  end
endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import mode_sp_pkg::*;
#(
  parameter int              SP_W       = 32,
  parameter int              ALIGN_BITS = 2,
  parameter logic [SP_W-1:0] MSP_RESET  = '0,
  parameter logic [SP_W-1:0] PSP_RESET  = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  sp_sel_e         wr_sel,
  input  logic [SP_W-1:0] wr_data,
  input  sp_sel_e         rd_sel_nxt,
  output logic [SP_W-1:0] rd_q
);
  localparam int              NUM_BANKS = 2;
  localparam logic [SP_W-1:0] KEEP_MASK = {{(SP_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [SP_W-1:0] aligned;
  logic [SP_W-1:0] bank_nxt [NUM_BANKS];

  assign aligned = wr_data & KEEP_MASK;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [SP_W-1:0] RST_V = (b == 0) ? MSP_RESET : PSP_RESET;
    logic [SP_W-1:0] q;
    logic            hit;

    assign hit         = wr_en && (int'(wr_sel) == b);
    assign bank_nxt[b] = hit ? aligned : q;

    always_ff @(posedge clk) begin
      if (rst) q <= RST_V;
      else     q <= bank_nxt[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= MSP_RESET;
    else     rd_q <= bank_nxt[int'(rd_sel_nxt)];
  end
endmodule

// File: rtl/mode_sp_unit.sv
module mode_sp_unit
  import mode_sp_pkg::*;
#(
  parameter int              SP_W       = 32,
  parameter int              DEPTH_W    = 3,
  parameter int              ALIGN_BITS = 2,
  parameter logic [SP_W-1:0] MSP_RESET  = 32'h2000_1000,
  parameter logic [SP_W-1:0] PSP_RESET  = 32'h2000_0800
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_enter,
  input  logic            exc_return,
  input  logic            ctl_we,
  input  logic            ctl_unpriv,
  input  logic            ctl_psel,
  input  logic            sp_we,
  input  logic [SP_W-1:0] sp_wdata,
  output logic            mode_handler,
  output logic            priv_eff,
  output logic            sp_is_process,
  output logic [SP_W-1:0] sp_rdata,
  output logic            priv_fault
);
  logic    handler_q;
  logic    handler_nxt;
  logic    unpriv_q;
  logic    psel_q;
  logic    unpriv_nxt;
  logic    psel_nxt;
  sp_sel_e sel_now;
  sp_sel_e sel_nxt;
  logic    priv_q;
  logic    proc_q;

  exc_nest_track #(.DEPTH_W(DEPTH_W)) u_nest (
    .clk            (clk),
    .rst            (rst),
    .enter          (exc_enter),
    .leave          (exc_return),
    .in_handler_q   (handler_q),
    .in_handler_nxt (handler_nxt)
  );

  priv_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .handler_now (handler_q),
    .we          (ctl_we),
    .wd_unpriv   (ctl_unpriv),
    .wd_psel     (ctl_psel),
    .unpriv_q    (unpriv_q),
    .psel_q      (psel_q),
    .unpriv_nxt  (unpriv_nxt),
    .psel_nxt    (psel_nxt),
    .fault_q     (priv_fault)
  );

  assign sel_now = pick_sp(handler_q, psel_q);
  assign sel_nxt = pick_sp(handler_nxt, psel_nxt);

  sp_bank #(
    .SP_W       (SP_W),
    .ALIGN_BITS (ALIGN_BITS),
    .MSP_RESET  (MSP_RESET),
    .PSP_RESET  (PSP_RESET)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (sp_we),
    .wr_sel     (sel_now),
    .wr_data    (sp_wdata),
    .rd_sel_nxt (sel_nxt),
    .rd_q       (sp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q <= 1'b1;
      proc_q <= 1'b0;
    end else begin
      priv_q <= handler_nxt || !unpriv_nxt;
      proc_q <= (sel_nxt == SP_PROC);
    end
  end

  assign mode_handler  = handler_q;
  assign priv_eff      = priv_q;
  assign sp_is_process = proc_q;
endmodule

// File: rtl/mode_sp_checker.sv
module mode_sp_checker #(
  parameter int SP_W       = 32,
  parameter int ALIGN_BITS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_enter,
  input logic            exc_return,
  input logic            ctl_we,
  input logic            mode_handler,
  input logic            priv_eff,
  input logic            sp_is_process,
  input logic [SP_W-1:0] sp_rdata,
  input logic            priv_fault
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!mode_handler && priv_eff && !sp_is_process && !priv_fault));

  a_r2_enter_handler: assert property (@(posedge clk) disable iff (rst)
    (exc_enter && !exc_return) |=> mode_handler);

  a_r3_handler_priv: assert property (@(posedge clk) disable iff (rst)
    mode_handler |-> priv_eff);

  a_r5_handler_main_sp: assert property (@(posedge clk) disable iff (rst)
    mode_handler |-> !sp_is_process);

  a_r7_sp_aligned: assert property (@(posedge clk) disable iff (rst)
    sp_rdata[ALIGN_BITS-1:0] == '0);

  a_r8_fault_raised: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !mode_handler && !priv_eff) |=> priv_fault);

  a_r8_no_spurious_fault: assert property (@(posedge clk) disable iff (rst)
    !(ctl_we && !mode_handler && !priv_eff) |=> !priv_fault);

  a_r8_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !mode_handler && !priv_eff && !exc_enter)
      |=> (!priv_eff && (sp_is_process == $past(sp_is_process))));

  a_r9_thread_return_ignored: assert property (@(posedge clk) disable iff (rst)
    (!mode_handler && exc_return && !exc_enter) |=> !mode_handler);
endmodule

bind mode_sp_unit mode_sp_checker #(
  .SP_W       (SP_W),
  .ALIGN_BITS (ALIGN_BITS)
) u_mode_sp_checker (
  .clk           (clk),
  .rst           (rst),
  .exc_enter     (exc_enter),
  .exc_return    (exc_return),
  .ctl_we        (ctl_we),
  .mode_handler  (mode_handler),
  .priv_eff      (priv_eff),
  .sp_is_process (sp_is_process),
  .sp_rdata      (sp_rdata),
  .priv_fault    (priv_fault)
);

// File: tb/test_mode_sp_unit.sv
module test_mode_sp_unit;
  localparam logic [31:0] MSP_INIT = 32'h2000_1000;
  localparam logic [31:0] PSP_INIT = 32'h2000_0800;
  localparam int          DMAX     = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_enter = 1'b0, exc_return = 1'b0;
  logic        ctl_we = 1'b0, ctl_unpriv = 1'b0, ctl_psel = 1'b0;
  logic        sp_we = 1'b0;
  logic [31:0] sp_wdata = '0;
  logic        mode_handler, priv_eff, sp_is_process, priv_fault;
  logic [31:0] sp_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int          m_depth;
  bit          m_unpriv, m_psel, m_fault;
  logic [31:0] m_msp, m_psp;

  mode_sp_unit #(
    .SP_W(32), .DEPTH_W(3), .ALIGN_BITS(2),
    .MSP_RESET(MSP_INIT), .PSP_RESET(PSP_INIT)
  ) i_mode_sp_unit (
    .clk(clk), .rst(rst), .exc_enter(exc_enter), .exc_return(exc_return),
    .ctl_we(ctl_we), .ctl_unpriv(ctl_unpriv), .ctl_psel(ctl_psel),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .mode_handler(mode_handler),
    .priv_eff(priv_eff), .sp_is_process(sp_is_process),
    .sp_rdata(sp_rdata), .priv_fault(priv_fault)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    bit h, sel_proc, ill, inc, dec;
    if (rst) begin
      m_depth = 0; m_unpriv = 0; m_psel = 0; m_fault = 0;
      m_msp = MSP_INIT; m_psp = PSP_INIT;
      return;
    end
    h        = (m_depth != 0);
    sel_proc = !h && m_psel;
    ill      = ctl_we && !h && m_unpriv;
    m_fault  = ill;
    if (sp_we) begin
      if (sel_proc) m_psp = sp_wdata & 32'hFFFF_FFFC;
      else          m_msp = sp_wdata & 32'hFFFF_FFFC;
    end
    if (ctl_we && !ill) begin
      m_unpriv = ctl_unpriv;
      m_psel   = ctl_psel;
    end
    inc = exc_enter && (m_depth != DMAX);
    dec = exc_return && (m_depth != 0);
    m_depth = m_depth + int'(inc) - int'(dec);
  endtask

  task automatic compare_all();
    bit h, sp_p;
    h    = (m_depth != 0);
    sp_p = !h && m_psel;
    chk("R2/R9 mode", {31'b0, mode_handler}, {31'b0, h});
    chk("R3/R4 privilege", {31'b0, priv_eff}, {31'b0, (h || !m_unpriv)});
    chk("R5 stack select", {31'b0, sp_is_process}, {31'b0, sp_p});
    chk("R6/R7 sp value", sp_rdata, sp_p ? m_psp : m_msp);
    chk("R8 fault", {31'b0, priv_fault}, {31'b0, m_fault});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    exc_enter = 0; exc_return = 0; ctl_we = 0; sp_we = 0;
  endtask

  task automatic do_enter();  exc_enter = 1; cyc(); endtask
  task automatic do_return(); exc_return = 1; cyc(); endtask
  task automatic do_ctl(input bit u, input bit p);
    ctl_we = 1; ctl_unpriv = u; ctl_psel = p; cyc();
  endtask
  task automatic do_sp(input logic [31:0] v);
    sp_we = 1; sp_wdata = v; cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1;
    cyc(); cyc();
    chk("R1 reset mode", {31'b0, mode_handler}, 32'd0);
    chk("R1 reset priv", {31'b0, priv_eff}, 32'd1);
    chk("R1 reset sp", sp_rdata, MSP_INIT);
    rst = 0;
    cyc();

    do_sp(32'h2000_0F07);
    chk("R7 aligned main write", sp_rdata, 32'h2000_0F04);

    do_ctl(0, 1);
    chk("R5 thread process select", {31'b0, sp_is_process}, 32'd1);
    chk("R6 process untouched", sp_rdata, PSP_INIT);
    do_sp(32'h2000_0703);
    chk("R6 R7 process write", sp_rdata, 32'h2000_0700);

    do_enter();
    chk("R2 handler entered", {31'b0, mode_handler}, 32'd1);
    chk("R5 handler main sp", sp_rdata, 32'h2000_0F04);
    do_sp(32'h2000_0E00);
    do_enter();
    do_return();
    chk("R9 nested still handler", {31'b0, mode_handler}, 32'd1);
    do_return();
    chk("R10 process restored", sp_rdata, 32'h2000_0700);
    do_return();
    chk("R9 thread return ignored", {31'b0, mode_handler}, 32'd0);

    do_ctl(1, 1);
    chk("R4 unprivileged thread", {31'b0, priv_eff}, 32'd0);
    do_ctl(0, 0);
    chk("R8 fault pulse", {31'b0, priv_fault}, 32'd1);
    chk("R8 write ignored", {31'b0, sp_is_process}, 32'd1);
    cyc();
    chk("R8 fault one cycle", {31'b0, priv_fault}, 32'd0);

    do_enter();
    chk("R3 handler privileged", {31'b0, priv_eff}, 32'd1);
    do_ctl(0, 0);
    chk("R8 handler write no fault", {31'b0, priv_fault}, 32'd0);
    do_return();
    chk("R10 privilege restored", {31'b0, priv_eff}, 32'd1);
    chk("R10 main selected", sp_rdata, 32'h2000_0E00);

    exc_enter = 1; exc_return = 1; cyc();
    chk("R11 both from thread", {31'b0, mode_handler}, 32'd1);
    exc_enter = 1; exc_return = 1; cyc();
    do_return();
    chk("R11 both keep depth", {31'b0, mode_handler}, 32'd0);

    for (int i = 0; i < 9; i++) do_enter();
    for (int i = 0; i < 6; i++) do_return();
    chk("R11 saturated depth", {31'b0, mode_handler}, 32'd1);
    do_return();
    chk("R11 saturated exit", {31'b0, mode_handler}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      exc_enter  = (r < 12);
      exc_return = (r >= 8 && r < 22);
      ctl_we     = (r >= 30 && r < 42);
      ctl_unpriv = $urandom_range(0, 1) == 1;
      ctl_psel   = $urandom_range(0, 1) == 1;
      sp_we      = (r >= 50 && r < 70);
      sp_wdata   = $urandom;
      if (r == 99) rst = 1;
      cyc();
      rst = 0;
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule